// File: doc/BRIEF.md
# Serial Pad Configuration Chain

This block holds the configuration of a row of I/O pads in one long shift register that is threaded through one small cell per pad. A management controller feeds a serial bit stream and a shift enable. Every cell takes its serial input from the cell before it and hands its top bit to the cell after it. When the whole stream is in place, a single apply strobe copies each cell's shift contents into a shadow register at once. The shadow register drives that pad's static option lines: drive mode, trip voltage, slew, input buffer mode, input disable, hold override and the analog options.

The shadow word also sets pad ownership. When its management-enable bit is set, the pad output and output enable come from the management side; otherwise they come from user logic. The pad input always goes to both sides. The first NBIDIR cells are fully bidirectional, with separate management output and output-enable inputs, and they reset to a push-pull output owned by management. The remaining cells are selectable cells that reset to plain inputs. In a selectable cell the management output is looped back from the pad input, and the output enable is taken from the stored output-disable bit alone. Pulling the loader reset low puts every cell back to its default, so pins that user logic has taken over return to management.

Top module: `padcfg_chain`

## Requirements
- R1: While shift_en is high, each rising clock edge shifts ser_in into bit 0 of cell 0. It also moves bit 12 of every cell into bit 0 of the next cell. ser_out shows bit 12 of the last cell and updates on the falling clock edge.
- R2: The chain behaves as one shift register of NPADS*13 bits. After NPADS*13 shifts the first bit sent sits in bit 12 of cell NPADS-1. A load therefore sends the word of cell NPADS-1 first, and each word is sent bit 12 first.
- R3: While shift_en is low, the shift contents hold whatever ser_in does.
- R4: The pad option lines and the routing change only on a rising edge with apply high, which copies the shift contents to the shadow register. Shifting without apply leaves every pad output unchanged.
- R5: Word fields, by bit: 12 management enable, 11 output disable, 10 hold override, 9 input disable, 8 input buffer mode, 7 analog enable, 6 analog select, 5 analog polarity, 4 slow slew, 3 trip select, 2:0 drive mode. Cell i drives pad_dm[3i+2:3i] and bit i of each one-bit option bus.
- R6: A rising edge with cfg_rst_n low loads both the shift and shadow registers with the defaults. Cells below NBIDIR default to 1_1_00000000_110; the other cells default to 1_1_00000000_001.
- R7: In a bidirectional cell with management enable 1, pad_out equals mgmt_out and pad_oeb equals (output disable AND mgmt_oeb).
- R8: In a selectable cell with management enable 1, pad_out equals that pad's pad_in and pad_oeb equals the output-disable bit.
- R9: In any cell with management enable 0, pad_out equals user_out and pad_oeb equals user_oeb.
- R10: mgmt_in and user_in both equal pad_in at all times, whatever the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial configuration clock |
| cfg_rst_n | input | 1 | Synchronous active-low loader reset to defaults |
| shift_en | input | 1 | Shift the chain one bit on this edge |
| apply | input | 1 | Copy shift contents to the shadow registers |
| ser_in | input | 1 | Serial data into cell 0 |
| ser_out | output | 1 | Serial data out of the last cell |
| mgmt_out | input | NBIDIR | Management output for bidirectional cells |
| mgmt_oeb | input | NBIDIR | Management output disable for bidirectional cells |
| mgmt_in | output | NPADS | Pad input as seen by management |
| user_out | input | NPADS | User output per pad |
| user_oeb | input | NPADS | User output disable per pad |
| user_in | output | NPADS | Pad input as seen by user logic |
| pad_in | input | NPADS | Input from the pad |
| pad_out | output | NPADS | Output to the pad |
| pad_oeb | output | NPADS | Output disable to the pad |
| pad_inp_dis | output | NPADS | Input disable option |
| pad_ib_mode | output | NPADS | Input buffer mode option |
| pad_vtrip | output | NPADS | Trip voltage select option |
| pad_slow | output | NPADS | Slow slew option |
| pad_hold_ovr | output | NPADS | Hold override option |
| pad_ana_en | output | NPADS | Analog enable option |
| pad_ana_sel | output | NPADS | Analog select option |
| pad_ana_pol | output | NPADS | Analog polarity option |
| pad_dm | output | 3*NPADS | Drive mode, three bits per pad |

## Verification
The assertions assume that shift_en, apply, ser_in and cfg_rst_n are steady around each rising edge. They also assume that reset is held low for at least one rising edge before any shift or apply. The bench meets both assumptions by changing every input a quarter period after the rising edge. It never raises apply and shift_en in the same cycle, so the value the shadow register captures is never ambiguous. It samples ser_out only after the falling edge, because that is when the serial output moves.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;

    localparam int CFG_W = 13;

    localparam logic [2:0] DM_PUSHPULL = 3'b110;
    localparam logic [2:0] DM_INPUT    = 3'b001;

    typedef struct packed {
        logic       mgmt_en;
        logic       oe_dis;
        logic       hold_ovr;
        logic       inp_dis;
        logic       ib_mode;
        logic       ana_en;
        logic       ana_sel;
        logic       ana_pol;
        logic       slow;
        logic       vtrip;
        logic [2:0] dm;
    } padcfg_t;

    function automatic padcfg_t cfg_default(input bit bidir);
        padcfg_t c;
        c         = '0;
        c.mgmt_en = 1'b1;
        c.oe_dis  = 1'b1;
        c.dm      = bidir ? DM_PUSHPULL : DM_INPUT;
        return c;
    endfunction

endpackage

// File: rtl/padcfg_shift.sv
module padcfg_shift
    import padcfg_pkg::*;
#(
    parameter bit BIDIR = 1'b0
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    shift_en,
    input  logic    apply,
    input  logic    sin,
    output logic    sout,
    output padcfg_t cfg
);

    localparam padcfg_t          DFLT      = cfg_default(BIDIR);
    localparam logic [CFG_W-1:0] DFLT_BITS = DFLT;

    logic [CFG_W-1:0] shift_q;
    padcfg_t          shadow_q;
    logic             sout_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= DFLT_BITS;
        end else if (shift_en) begin
            shift_q <= {shift_q[CFG_W-2:0], sin};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= DFLT;
        end else if (apply) begin
            shadow_q <= padcfg_t'(shift_q);
        end
    end

    // Top bit launched on the falling edge: half a period of hold margin
    // for the neighbour that samples it on the next rising edge.
    always_ff @(negedge clk) begin
        sout_q <= shift_q[CFG_W-1];
    end

    assign sout = sout_q;
    assign cfg  = shadow_q;

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> shift_q[CFG_W-1:1] == $past(shift_q[CFG_W-2:0])); // R1

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(shift_q)); // R3

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(shadow_q)); // R4

    AST_RESET_DEFAULT: assert property (@(posedge clk)
        !rst_n |=> (shadow_q == DFLT) && (shift_q == DFLT_BITS)); // R6

endmodule

// File: rtl/padcfg_route.sv
module padcfg_route
    import padcfg_pkg::*;
(
    input  padcfg_t    cfg,
    input  logic       mgmt_out,
    input  logic       mgmt_oeb,
    input  logic       user_out,
    input  logic       user_oeb,
    input  logic       pad_in,
    output logic       pad_out,
    output logic       pad_oeb,
    output logic       mgmt_in,
    output logic       user_in,
    output logic       inp_dis,
    output logic       ib_mode,
    output logic       vtrip,
    output logic       slow,
    output logic       hold_ovr,
    output logic       ana_en,
    output logic       ana_sel,
    output logic       ana_pol,
    output logic [2:0] dm
);

    always_comb begin
        if (cfg.mgmt_en) begin
            pad_out = mgmt_out;
            pad_oeb = cfg.oe_dis & mgmt_oeb;
        end else begin
            pad_out = user_out;
            pad_oeb = user_oeb;
        end
    end

    assign mgmt_in  = pad_in;
    assign user_in  = pad_in;

    assign inp_dis  = cfg.inp_dis;
    assign ib_mode  = cfg.ib_mode;
    assign vtrip    = cfg.vtrip;
    assign slow     = cfg.slow;
    assign hold_ovr = cfg.hold_ovr;
    assign ana_en   = cfg.ana_en;
    assign ana_sel  = cfg.ana_sel;
    assign ana_pol  = cfg.ana_pol;
    assign dm       = cfg.dm;

endmodule

// File: rtl/padcfg_cell.sv
module padcfg_cell
    import padcfg_pkg::*;
#(
    parameter bit BIDIR = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       apply,
    input  logic       sin,
    output logic       sout,
    input  logic       mgmt_out,
    input  logic       mgmt_oeb,
    input  logic       user_out,
    input  logic       user_oeb,
    input  logic       pad_in,
    output logic       pad_out,
    output logic       pad_oeb,
    output logic       mgmt_in,
    output logic       user_in,
    output logic       inp_dis,
    output logic       ib_mode,
    output logic       vtrip,
    output logic       slow,
    output logic       hold_ovr,
    output logic       ana_en,
    output logic       ana_sel,
    output logic       ana_pol,
    output logic [2:0] dm
);

    padcfg_t cfg;

    padcfg_shift #(.BIDIR(BIDIR)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .apply    (apply),
        .sin      (sin),
        .sout     (sout),
        .cfg      (cfg)
    );

    padcfg_route u_route (
        .cfg      (cfg),
        .mgmt_out (mgmt_out),
        .mgmt_oeb (mgmt_oeb),
        .user_out (user_out),
        .user_oeb (user_oeb),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oeb  (pad_oeb),
        .mgmt_in  (mgmt_in),
        .user_in  (user_in),
        .inp_dis  (inp_dis),
        .ib_mode  (ib_mode),
        .vtrip    (vtrip),
        .slow     (slow),
        .hold_ovr (hold_ovr),
        .ana_en   (ana_en),
        .ana_sel  (ana_sel),
        .ana_pol  (ana_pol),
        .dm       (dm)
    );

endmodule

// File: rtl/padcfg_chain.sv
module padcfg_chain
    import padcfg_pkg::*;
#(
    parameter int NPADS  = 8,
    parameter int NBIDIR = 2
) (
    input  logic                 clk,
    input  logic                 cfg_rst_n,
    input  logic                 shift_en,
    input  logic                 apply,
    input  logic                 ser_in,
    output logic                 ser_out,
    input  logic [NBIDIR-1:0]    mgmt_out,
    input  logic [NBIDIR-1:0]    mgmt_oeb,
    output logic [NPADS-1:0]     mgmt_in,
    input  logic [NPADS-1:0]     user_out,
    input  logic [NPADS-1:0]     user_oeb,
    output logic [NPADS-1:0]     user_in,
    input  logic [NPADS-1:0]     pad_in,
    output logic [NPADS-1:0]     pad_out,
    output logic [NPADS-1:0]     pad_oeb,
    output logic [NPADS-1:0]     pad_inp_dis,
    output logic [NPADS-1:0]     pad_ib_mode,
    output logic [NPADS-1:0]     pad_vtrip,
    output logic [NPADS-1:0]     pad_slow,
    output logic [NPADS-1:0]     pad_hold_ovr,
    output logic [NPADS-1:0]     pad_ana_en,
    output logic [NPADS-1:0]     pad_ana_sel,
    output logic [NPADS-1:0]     pad_ana_pol,
    output logic [3*NPADS-1:0]   pad_dm
);

    localparam int CHAIN_BITS = NPADS * CFG_W;

    initial begin
        if (NBIDIR < 1 || NBIDIR > NPADS || CHAIN_BITS < CFG_W) begin
            $display("padcfg_chain: bad NBIDIR %0d for NPADS %0d", NBIDIR, NPADS);
        end
    end

    logic [NPADS:0] link;

    assign link[0] = ser_in;
    assign ser_out = link[NPADS];

    for (genvar i = 0; i < NPADS; i++) begin : g_pad
        logic m_out;
        logic m_oeb;

        if (i < NBIDIR) begin : g_bidir
            assign m_out = mgmt_out[i];
            assign m_oeb = mgmt_oeb[i];
        end else begin : g_sel
            // Selectable pad: management output looped from the pad input,
            // management output disable held high so the stored bit decides.
            assign m_out = pad_in[i];
            assign m_oeb = 1'b1;
        end

        padcfg_cell #(.BIDIR(i < NBIDIR)) u_cell (
            .clk      (clk),
            .rst_n    (cfg_rst_n),
            .shift_en (shift_en),
            .apply    (apply),
            .sin      (link[i]),
            .sout     (link[i+1]),
            .mgmt_out (m_out),
            .mgmt_oeb (m_oeb),
            .user_out (user_out[i]),
            .user_oeb (user_oeb[i]),
            .pad_in   (pad_in[i]),
            .pad_out  (pad_out[i]),
            .pad_oeb  (pad_oeb[i]),
            .mgmt_in  (mgmt_in[i]),
            .user_in  (user_in[i]),
            .inp_dis  (pad_inp_dis[i]),
            .ib_mode  (pad_ib_mode[i]),
            .vtrip    (pad_vtrip[i]),
            .slow     (pad_slow[i]),
            .hold_ovr (pad_hold_ovr[i]),
            .ana_en   (pad_ana_en[i]),
            .ana_sel  (pad_ana_sel[i]),
            .ana_pol  (pad_ana_pol[i]),
            .dm       (pad_dm[3*i +: 3])
        );
    end

endmodule

// File: tb/sim_padcfg_chain.sv
`timescale 1ns/1ps
module sim_padcfg_chain;

    localparam int NP = 4;
    localparam int NB = 2;

    localparam logic [12:0] DEF_B = 13'b1_1_00000000_110;
    localparam logic [12:0] DEF_I = 13'b1_1_00000000_001;

    localparam logic [12:0] WA [4] = '{
        13'b0_0_10101010_011,
        13'b1_0_01010101_100,
        13'b1_0_11110000_010,
        13'b0_1_00001111_101
    };

    // {pad_in[3:0], user_out[3:0], user_oeb[3:0], mgmt_out[1:0], mgmt_oeb[1:0]}
    localparam logic [15:0] RT [4] = '{16'h5A36, 16'hA5C9, 16'hF0F0, 16'h0F0F};

    logic clk = 1'b0;
    logic cfg_rst_n = 1'b0;
    logic shift_en = 1'b0;
    logic apply = 1'b0;
    logic ser_in = 1'b0;
    logic ser_out;
    logic [NB-1:0] mgmt_out = '0;
    logic [NB-1:0] mgmt_oeb = '0;
    logic [NP-1:0] mgmt_in, user_in, pad_out, pad_oeb;
    logic [NP-1:0] user_out = '0;
    logic [NP-1:0] user_oeb = '0;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_inp_dis, pad_ib_mode, pad_vtrip, pad_slow, pad_hold_ovr;
    logic [NP-1:0] pad_ana_en, pad_ana_sel, pad_ana_pol;
    logic [3*NP-1:0] pad_dm;

    int tests = 0;
    int fails = 0;
    logic [12:0] cur [4];

    always #10 clk = ~clk;

    padcfg_chain #(.NPADS(NP), .NBIDIR(NB)) u0 (
        .clk(clk), .cfg_rst_n(cfg_rst_n), .shift_en(shift_en), .apply(apply),
        .ser_in(ser_in), .ser_out(ser_out),
        .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb), .mgmt_in(mgmt_in),
        .user_out(user_out), .user_oeb(user_oeb), .user_in(user_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oeb(pad_oeb),
        .pad_inp_dis(pad_inp_dis), .pad_ib_mode(pad_ib_mode), .pad_vtrip(pad_vtrip),
        .pad_slow(pad_slow), .pad_hold_ovr(pad_hold_ovr), .pad_ana_en(pad_ana_en),
        .pad_ana_sel(pad_ana_sel), .pad_ana_pol(pad_ana_pol), .pad_dm(pad_dm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic send_word(input logic [12:0] w);
        for (int b = 12; b >= 0; b--) begin
            ser_in   = w[b];
            shift_en = 1'b1;
            tick();
        end
        shift_en = 1'b0;
    endtask

    task automatic do_apply();
        apply = 1'b1;
        tick();
        apply = 1'b0;
    endtask

    // R5 field layout: bit 10 hold, 9 inp_dis, 8 ib, 7 ana_en, 6 ana_sel, 5 ana_pol, 4 slow, 3 vtrip, 2:0 dm
    task automatic check_opts(input string req, input logic [12:0] w [4]);
        for (int c = 0; c < NP; c++) begin
            chk(req, {21'd0, pad_hold_ovr[c], pad_inp_dis[c], pad_ib_mode[c], pad_ana_en[c],
                      pad_ana_sel[c], pad_ana_pol[c], pad_slow[c], pad_vtrip[c], pad_dm[3*c +: 3]},
                {21'd0, w[c][10:0]});
        end
    endtask

    task automatic check_routes();
        for (int v = 0; v < 4; v++) begin
            {pad_in, user_out, user_oeb, mgmt_out, mgmt_oeb} = RT[v];
            #1;
            for (int c = 0; c < NP; c++) begin
                logic eo, eb;
                string tag;
                if (!cur[c][12]) begin
                    eo = user_out[c]; eb = user_oeb[c]; tag = "R9 user routing";
                end else if (c < NB) begin
                    eo = mgmt_out[c]; eb = cur[c][11] & mgmt_oeb[c]; tag = "R7 bidir routing";
                end else begin
                    eo = pad_in[c]; eb = cur[c][11]; tag = "R8 selectable routing";
                end
                chk(tag, {30'd0, pad_out[c], pad_oeb[c]}, {30'd0, eo, eb});
            end
            chk("R10 input fanout", {24'd0, mgmt_in, user_in}, {24'd0, pad_in, pad_in});
        end
    endtask

    task automatic set_defaults(output logic [12:0] w [4]);
        for (int c = 0; c < NP; c++) w[c] = (c < NB) ? DEF_B : DEF_I;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [12:0] dflt [4];
        logic [12:0] wb [4];
        set_defaults(dflt);

        // R6 reset state
        repeat (3) tick();
        cur = dflt;
        check_opts("R6 reset options", dflt);
        check_routes();
        cfg_rst_n = 1'b1;
        tick();
        #10;
        chk("R1 ser_out after reset", {31'd0, ser_out}, {31'd0, DEF_I[12]});

        // R4 partial load does not reach the pads
        send_word(WA[3]);
        send_word(WA[2]);
        check_opts("R4 partial shift no effect", dflt);
        send_word(WA[1]);
        send_word(WA[0]);
        check_opts("R4 full shift before apply", dflt);
        do_apply();
        cur = WA;
        check_opts("R2/R5 reversed placement", WA);
        check_routes();

        // R1 stream out of the last cell, top bit first
        #10;
        chk("R1 ser_out bit 12", {31'd0, ser_out}, {31'd0, WA[3][12]});
        for (int k = 1; k <= 12; k++) begin
            ser_in   = 1'b0;
            shift_en = 1'b1;
            tick();
            #10;
            chk("R1 ser_out stream", {31'd0, ser_out}, {31'd0, WA[3][12-k]});
        end
        shift_en = 1'b0;
        check_opts("R4 shift without apply", WA);

        // R6 reset after user takeover
        cfg_rst_n = 1'b0;
        tick();
        cfg_rst_n = 1'b1;
        cur = dflt;
        check_opts("R6 reset restores defaults", dflt);
        check_routes();

        // R3 shift_en low: ser_in activity is ignored
        for (int k = 0; k < 20; k++) begin
            ser_in = k[0];
            tick();
        end
        do_apply();
        check_opts("R3 hold while shift_en low", dflt);
        #10;
        chk("R3 ser_out held", {31'd0, ser_out}, {31'd0, DEF_I[12]});

        // R2 second load with words moved to other cells
        wb[0] = WA[1]; wb[1] = WA[2]; wb[2] = WA[3]; wb[3] = WA[0];
        for (int c = NP - 1; c >= 0; c--) send_word(wb[c]);
        do_apply();
        cur = wb;
        check_opts("R2 second placement", wb);
        check_routes();

        summary();
    end

endmodule